// File: doc/BRIEF.md
# Branch History Record Buffer

This block keeps a rolling history of the most recent control transfers retired by a processor core. Each retired transfer arrives with its source address, its target address and a 3-bit type code. A software-written type mask picks which kinds of transfer are kept. Accepted transfers go into a circular store, and the oldest entry is lost once the store is full. When a performance counter overflows, an input called `freeze` holds the history unchanged, so the overflow handler can read it intact.

An optional return-stack mode treats the store as a call stack. A call adds an entry. A return removes the newest entry and is not itself recorded. Software reads entries through an index plus a word-select code, and index 0 is always the newest entry. A single access-enable bit gates every software read and write. A clear strobe empties the store in one cycle.

Top module: `branch_hist_buf`

## Requirements
- R1: Type codes are 0 none, 1 conditional taken branch, 2 direct jump, 3 indirect jump, 4 call, 5 return, 6 trap, 7 trap return. A transfer with `rec_valid` high is accepted only when bit `rec_type` of the filter mask is set. Rejected transfers leave the history unchanged.
- R2: While `freeze` is high, no transfer adds or removes an entry.
- R3: `rd_data` is registered and shows the word selected in the previous cycle. The select codes are: `rd_sel`=0 for the source address, 1 for the target address, 2 for the data word. The data word has bit AW-1 as the valid flag and bits 2:0 as the type, with all other bits zero. Index 0 is the newest entry and index i is the entry i places older.
- R4: When a transfer is accepted with DEPTH entries held, it overwrites the oldest entry and the count stays at DEPTH.
- R5: With return-stack mode on, an accepted return (type 5) removes the newest entry and is not recorded. Every other accepted type, including calls, adds an entry.
- R6: A return-stack removal while the buffer is empty leaves it unchanged.
- R7: A clear strobe (`cfg_clear` with access enabled) empties the buffer by the next cycle. It takes priority over a transfer in the same cycle.
- R8: An index at or beyond the current entry count reads as zero for every select code, and select code 3 always reads zero.
- R9: While `access_en` is low, `rd_data` is zero in the following cycle, and `cfg_we` and `cfg_clear` have no effect.
- R10: After reset the buffer is empty, the filter mask is zero and return-stack mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | A transfer retires this cycle |
| rec_src | input | AW | Transfer source address |
| rec_dst | input | AW | Transfer target address |
| rec_type | input | 3 | Transfer type code |
| freeze | input | 1 | Counter overflow hold |
| access_en | input | 1 | Software access enable bit |
| cfg_we | input | 1 | Write filter mask and mode |
| cfg_filter | input | 8 | Filter mask, bit n enables type n |
| cfg_ras | input | 1 | Return-stack mode value |
| cfg_clear | input | 1 | Clear strobe |
| rd_idx | input | IW | Entry index, 0 = newest |
| rd_sel | input | 2 | Word select |
| rd_data | output | AW | Registered read word |

## Verification
The tests feed the buffer a sweep of every type code under a sparse mask, which separates correct filtering from an off-by-one decode of the mask bit. A short burst of transfers followed by a long burst tests ordering from newest to oldest and reads beyond the count, and then wraparound with the oldest entry lost. A call, call, jump and return pattern with surplus returns in return-stack mode separates a pop from a push and shows what happens at the empty boundary. Freezing, clearing together with a transfer, and disabling access with entries present each show that a blocked action left the readable history untouched.

// File: rtl/bhb_pkg.sv
package bhb_pkg;
  typedef enum logic [2:0] {
    XT_NONE  = 3'd0,
    XT_BR    = 3'd1,
    XT_JMP   = 3'd2,
    XT_IJMP  = 3'd3,
    XT_CALL  = 3'd4,
    XT_RET   = 3'd5,
    XT_TRAP  = 3'd6,
    XT_TRET  = 3'd7
  } xfer_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
endpackage

// File: rtl/bhb_filter.sv
module bhb_filter (
  input  logic       clk,
  input  logic       rst,
  input  logic       rec_valid,
  input  logic [2:0] rec_type,
  input  logic [7:0] filter,
  input  logic       ras_mode,
  input  logic       freeze,
  output logic       push,
  output logic       pop
);
  import bhb_pkg::*;
  logic hit, is_ret;

  always_comb begin
    hit    = rec_valid && !freeze && filter[rec_type];
    is_ret = (rec_type == XT_RET);
    push   = hit && !(ras_mode && is_ret);
    pop    = hit && ras_mode && is_ret;
  end

  // R2: frozen core never changes history
  assert_freeze_hold_R2: assert property (@(posedge clk) disable iff (rst)
    freeze |-> (!push && !pop));
  // R1: masked-out type is never accepted
  assert_mask_block_R1: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !filter[rec_type]) |-> (!push && !pop));
endmodule

// File: rtl/bhb_ptr.sv
module bhb_ptr #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  output logic [IW-1:0] wptr,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wptr  <= '0;
      count <= '0;
    end else if (push) begin
      wptr <= wptr + 1'b1;
      if (count != FULL) count <= count + 1'b1;
    end else if (pop && count != '0) begin
      wptr  <= wptr - 1'b1;
      count <= count - 1'b1;
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  assert_full_saturate_R4: assert property (@(posedge clk) disable iff (rst)
    (push && !clear && count == FULL) |=> count == FULL);
  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !clear && count == '0) |=> (count == '0 && $stable(wptr)));
  assert_clear_empty_R7: assert property (@(posedge clk) disable iff (rst)
    clear |=> count == '0);
endmodule

// File: rtl/bhb_store.sv
module bhb_store #(
  parameter int DEPTH = 16,
  parameter int AW = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [AW-1:0] wsrc,
  input  logic [AW-1:0] wdst,
  input  logic [2:0]    wtype,
  input  logic          rd_ok,
  input  logic [IW-1:0] rd_idx,
  input  logic [1:0]    rd_sel,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] rd_data
);
  import bhb_pkg::*;

  logic [AW-1:0] src_mem [DEPTH];
  logic [AW-1:0] dst_mem [DEPTH];
  logic [2:0]    typ_mem [DEPTH];
  logic [IW-1:0] raddr;
  logic          in_range;

  always_ff @(posedge clk) begin
    if (we) begin
      src_mem[waddr] <= wsrc;
      dst_mem[waddr] <= wdst;
      typ_mem[waddr] <= wtype;
    end
  end

  always_comb begin
    raddr    = waddr - 1'b1 - rd_idx;
    in_range = CW'(rd_idx) < count;
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_ok || !in_range) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        SEL_SRC:  rd_data <= src_mem[raddr];
        SEL_DST:  rd_data <= dst_mem[raddr];
        SEL_DATA: rd_data <= {1'b1, {(AW-4){1'b0}}, typ_mem[raddr]};
        default:  rd_data <= '0;
      endcase
    end
  end

  // R8: out-of-range index reads zero
  assert_oob_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (CW'(rd_idx) >= count) |=> rd_data == '0);
endmodule

// File: rtl/branch_hist_buf.sv
module branch_hist_buf #(
  parameter int DEPTH = 16,
  parameter int AW = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rec_valid,
  input  logic [AW-1:0] rec_src,
  input  logic [AW-1:0] rec_dst,
  input  logic [2:0]    rec_type,
  input  logic          freeze,
  input  logic          access_en,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_filter,
  input  logic          cfg_ras,
  input  logic          cfg_clear,
  input  logic [IW-1:0] rd_idx,
  input  logic [1:0]    rd_sel,
  output logic [AW-1:0] rd_data
);
  logic [7:0]    filter_q;
  logic          ras_q;
  logic          clr;
  logic          push, pop;
  logic [IW-1:0] wptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      filter_q <= '0;
      ras_q    <= 1'b0;
    end else if (access_en && cfg_we) begin
      filter_q <= cfg_filter;
      ras_q    <= cfg_ras;
    end
  end

  assign clr = access_en && cfg_clear;

  bhb_filter u_filt (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_type(rec_type),
    .filter(filter_q), .ras_mode(ras_q), .freeze(freeze),
    .push(push), .pop(pop)
  );

  bhb_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .clear(clr), .push(push), .pop(pop),
    .wptr(wptr), .count(count)
  );

  bhb_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .we(push && !clr), .waddr(wptr),
    .wsrc(rec_src), .wdst(rec_dst), .wtype(rec_type),
    .rd_ok(access_en), .rd_idx(rd_idx), .rd_sel(rd_sel),
    .count(count), .rd_data(rd_data)
  );

  // R9: disabled access reads zero
  assert_gate_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !access_en |=> rd_data == '0);
  // R9: config held while disabled
  assert_gate_cfg_R9: assert property (@(posedge clk) disable iff (rst)
    !access_en |=> ($stable(filter_q) && $stable(ras_q)));
endmodule

// File: tb/sim_branch_hist_buf.sv
module sim_branch_hist_buf;
  localparam int DEPTH = 16;
  localparam int AW = 32;
  localparam int IW = $clog2(DEPTH);

  logic clk = 0, rst = 1;
  logic rec_valid = 0, freeze = 0, access_en = 1;
  logic [AW-1:0] rec_src = 0, rec_dst = 0;
  logic [2:0] rec_type = 0;
  logic cfg_we = 0, cfg_ras = 0, cfg_clear = 0;
  logic [7:0] cfg_filter = 0;
  logic [IW-1:0] rd_idx = 0;
  logic [1:0] rd_sel = 0;
  logic [AW-1:0] rd_data;

  int n_run = 0, n_fail = 0, seq = 0;
  logic [7:0] m_filter = 0;
  logic m_ras = 0;
  logic [AW-1:0] q_src[$], q_dst[$];
  logic [2:0] q_typ[$];

  always #2.5 clk = ~clk;

  branch_hist_buf #(.DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_src(rec_src),
    .rec_dst(rec_dst), .rec_type(rec_type), .freeze(freeze),
    .access_en(access_en), .cfg_we(cfg_we), .cfg_filter(cfg_filter),
    .cfg_ras(cfg_ras), .cfg_clear(cfg_clear), .rd_idx(rd_idx),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, input int sel, output logic [AW-1:0] v);
    rd_idx = IW'(idx); rd_sel = 2'(sel);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic cfg(logic [7:0] f, logic r);
    cfg_we = 1; cfg_filter = f; cfg_ras = r;
    @(negedge clk);
    cfg_we = 0;
    if (access_en) begin m_filter = f; m_ras = r; end
  endtask

  task automatic clear();
    cfg_clear = 1;
    @(negedge clk);
    cfg_clear = 0;
    if (access_en) begin q_src.delete(); q_dst.delete(); q_typ.delete(); end
  endtask

  task automatic rec(logic [2:0] t);
    seq++;
    rec_valid = 1; rec_type = t;
    rec_src = 32'h1000_0000 + seq * 16; rec_dst = 32'h2000_0000 + seq;
    @(negedge clk);
    rec_valid = 0;
    if (!freeze && m_filter[t]) begin
      if (m_ras && t == 3'd5) begin
        if (q_src.size() > 0) begin
          void'(q_src.pop_front()); void'(q_dst.pop_front()); void'(q_typ.pop_front());
        end
      end else begin
        q_src.push_front(rec_src); q_dst.push_front(rec_dst); q_typ.push_front(t);
        if (q_src.size() > DEPTH) begin
          void'(q_src.pop_back()); void'(q_dst.pop_back()); void'(q_typ.pop_back());
        end
      end
    end
  endtask

  task automatic check_all(string req);
    logic [AW-1:0] v, e;
    for (int i = 0; i < DEPTH; i++) begin
      for (int s = 0; s < 4; s++) begin
        rd(i, s, v);
        e = '0;
        if (i < q_src.size()) begin
          if (s == 0) e = q_src[i];
          else if (s == 1) e = q_dst[i];
          else if (s == 2) e = {1'b1, {(AW-4){1'b0}}, q_typ[i]};
        end
        chk($sformatf("%s idx%0d sel%0d", req, i, s), v, e);
      end
    end
  endtask

  task automatic t_reset();
    logic [AW-1:0] v;
    rd(0, 2, v); chk("R10 data0 after reset", v, '0);
    rd(0, 0, v); chk("R10 src0 after reset", v, '0);
    rec(3'd1); // filter zero after reset: nothing recorded
    check_all("R10 zero filter");
  endtask

  task automatic t_filter();
    cfg(8'h0A, 0);
    for (int t = 0; t < 8; t++) rec(3'(t));
    check_all("R1 mask 0x0A");
    clear();
  endtask

  task automatic t_order();
    cfg(8'hFF, 0);
    for (int k = 0; k < 5; k++) rec(3'(k + 1));
    check_all("R3 R8 partial order");
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 20; k++) rec(3'(k % 8));
    check_all("R4 wrap overwrite");
  endtask

  task automatic t_freeze();
    freeze = 1;
    for (int k = 0; k < 4; k++) rec(3'd2);
    freeze = 0;
    check_all("R2 freeze");
  endtask

  task automatic t_clear();
    cfg_clear = 1; rec(3'd2);
    cfg_clear = 0;
    q_src.delete(); q_dst.delete(); q_typ.delete();
    check_all("R7 clear beats record");
  endtask

  task automatic t_ras();
    cfg(8'hFF, 1);
    rec(3'd4); rec(3'd4); rec(3'd2); rec(3'd5);
    check_all("R5 call/ret stack");
    rec(3'd5); rec(3'd5); rec(3'd5);
    check_all("R6 pop at empty");
    rec(3'd4);
    check_all("R6 push after empty pop");
    cfg(8'hFF, 0);
  endtask

  task automatic t_gate();
    logic [AW-1:0] v;
    rec(3'd3); rec(3'd6);
    access_en = 0;
    rd(0, 0, v); chk("R9 gated read src", v, '0);
    rd(1, 2, v); chk("R9 gated read data", v, '0);
    cfg(8'h00, 1);
    clear();
    access_en = 1;
    rec(3'd7);
    check_all("R9 writes ignored when disabled");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset(); t_filter(); t_order(); t_wrap(); t_freeze();
    t_clear(); t_ras(); t_gate();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule